// File: doc/BRIEF.md
# Serial Port Register Front-End

This block sits between a simple register bus and the serial shifter of a synchronous serial port. Software writes 16-bit frames to a data register, which queues them in an eight-entry transmit FIFO. Reading the same address dequeues the oldest frame from an eight-entry receive FIFO. A read-only status register reports the FIFO levels, a busy condition and a sticky receive-overrun flag. A control register holds the port enable, the master/slave choice, a slave output disable and a frame-length code.

The shifter collects transmit frames through a valid/ready handshake and hands back received frames as single-cycle pulses. The block also drives one output-enable flag for each of the four serial lines, based on the mode and the enable. Register reads are combinational. A data-register read pops the receive FIFO at the clock edge that ends the access.

Register map, selected by `reg_sel`:
- 0: control
- 1: data
- 2: status

Control fields:
- bit 1: enable
- bit 2: mode (0 = master, 1 = slave)
- bit 3: slave output disable
- bit 4: overrun clear (write 1 to clear; reads as 0)
- bits 11:8: length code

Status bits:
- bit 0: transmit empty
- bit 1: transmit not full
- bit 2: receive not empty
- bit 3: receive full
- bit 4: busy
- bit 5: overrun

Top module: `sport_regfront`

## Requirements
- R1: After reset, the status register reads 0x0003, the control register reads 0x0F00, a data read returns 0x0000, and all four line enables are 0.
- R2: Writing the data register pushes the word into the transmit FIFO. After 8 queued frames, status bit 1 (transmit not full) is 0 and bit 0 (transmit empty) is 0. A further write is dropped, unless a handoff to the shifter takes place in the same cycle.
- R3: A data read returns the oldest received frame, masked to the frame length with the upper bits zero. The length is code+1 for codes 3..15, and 4 bits for codes 0..2.
- R4: A data read while the receive FIFO is empty returns 0 and changes no pointer. A frame pushed afterwards is the next frame read.
- R5: `tx_valid` is 1 exactly when the port is enabled and the transmit FIFO holds a frame. `tx_data` is the oldest queued frame. A frame leaves the FIFO on a cycle where both `tx_valid` and `tx_ready` are 1, so a frame written to an empty FIFO is offered on the next cycle.
- R6: The mode bit takes a written value only if the enable bit was 0 before the write. While the port is enabled, the mode bit holds its value.
- R7: When disabled, all line enables are 0. In master mode, the clock, data-out and select enables are 1 and the input-line enable is 0. In slave mode, only the input-line enable can be 1, and it is 0 when the slave output disable is set. The disable bit has no effect in master mode.
- R8: A received frame arriving while the receive FIFO is full, with no pop in the same cycle, is discarded and sets status bit 5. The bit stays set until a control write with bit 4 set. A set and a clear in the same cycle leave the bit set.
- R9: Status bit 4 (busy) is 1 whenever the transmit FIFO is not empty or `shifter_active` is 1.
- R10: A received frame that arrives in the same cycle as a data read of a full receive FIFO is stored. No overrun is flagged, and the FIFO stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select: 0 control, 1 data, 2 status |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops on data reads) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register |
| tx_valid | output | 1 | Transmit frame offered to the shifter |
| tx_data | output | 16 | Offered transmit frame |
| tx_ready | input | 1 | Shifter takes the offered frame |
| rx_valid | input | 1 | Received frame strobe from the shifter |
| rx_data | input | 16 | Received frame |
| shifter_active | input | 1 | Shifter is mid-frame |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi_oe | output | 1 | Master data-out output enable |
| ssel_oe | output | 1 | Select output enable |
| miso_oe | output | 1 | Slave data-out output enable |

## Verification
Two collisions can occur. A software pop of the receive FIFO can coincide with a frame arriving from the shifter. A software push into the transmit FIFO can coincide with a handoff to the shifter.

The bench fills the receive FIFO and then raises a data read and `rx_valid` in the same cycle. It judges the result by three observations: the value read, the absence of the overrun flag, and the full order of the eight frames drained afterwards. The transmit case is provoked by writing while the FIFO is full and `tx_ready` is high. The offered sequence must then include the late frame.

// File: rtl/sport_regfront.sv
module sport_regfront #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          shifter_active,
  output logic          sclk_oe,
  output logic          mosi_oe,
  output logic          ssel_oe,
  output logic          miso_oe
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW:0]   tx_wp, tx_rp, rx_wp, rx_rp;
  logic          en_q, mode_q, sod_q, ovr_q;
  logic [3:0]    len_q;

  logic sel_ctrl, sel_data, sel_stat;
  assign sel_ctrl = reg_sel == 2'd0;
  assign sel_data = reg_sel == 2'd1;
  assign sel_stat = reg_sel == 2'd2;

  logic [AW:0] tx_cnt, rx_cnt;
  assign tx_cnt = tx_wp - tx_rp;
  assign rx_cnt = rx_wp - rx_rp;

  logic tx_empty, tx_full, rx_empty, rx_full;
  assign tx_empty = tx_cnt == '0;
  assign tx_full  = tx_cnt == FULL;
  assign rx_empty = rx_cnt == '0;
  assign rx_full  = rx_cnt == FULL;

  logic tx_pop, tx_push, rx_pop, rx_push;
  assign tx_valid = en_q & ~tx_empty;
  assign tx_data  = tx_mem[tx_rp[AW-1:0]];
  assign tx_pop   = tx_valid & tx_ready;
  assign tx_push  = wr_en & sel_data & (~tx_full | tx_pop);
  assign rx_pop   = rd_en & sel_data & ~rx_empty;
  assign rx_push  = rx_valid & (~rx_full | rx_pop);

  logic busy;
  assign busy = ~tx_empty | shifter_active;

  int unsigned  flen;
  logic [31:0]  mask;
  assign flen = (len_q < 4'd3) ? 4 : int'(len_q) + 1;
  assign mask = (32'd1 << flen) - 32'd1;

  logic [15:0] ctrl_rd, stat_rd;
  assign ctrl_rd = {4'b0, len_q, 4'b0, sod_q, mode_q, en_q, 1'b0};
  assign stat_rd = {10'b0, ovr_q, busy, rx_full, ~rx_empty, ~tx_full, tx_empty};

  always_comb begin
    rdata = '0;
    if (sel_ctrl)      rdata = DW'(ctrl_rd);
    else if (sel_stat) rdata = DW'(stat_rd);
    else if (sel_data && !rx_empty) rdata = rx_mem[rx_rp[AW-1:0]] & mask[DW-1:0];
  end

  assign sclk_oe = en_q & ~mode_q;
  assign mosi_oe = en_q & ~mode_q;
  assign ssel_oe = en_q & ~mode_q;
  assign miso_oe = en_q & mode_q & ~sod_q;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp[AW-1:0]] <= wdata;
    if (rx_push) rx_mem[rx_wp[AW-1:0]] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; mode_q <= 1'b0; sod_q <= 1'b0; ovr_q <= 1'b0; len_q <= 4'hF;
    end else begin
      if (wr_en && sel_ctrl) begin
        en_q  <= wdata[1];
        sod_q <= wdata[3];
        len_q <= wdata[11:8];
        if (!en_q) mode_q <= wdata[2];
      end
      ovr_q <= (rx_valid & rx_full & ~rx_pop) | (ovr_q & ~(wr_en & sel_ctrl & wdata[4]));
    end
  end
endmodule

// File: rtl/sport_regfront_chk.sv
module sport_regfront_chk #(
  parameter int DW = 16,
  parameter int CW = 4,
  parameter int DEPTH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    reg_sel,
  input logic          wr_en,
  input logic          rd_en,
  input logic [DW-1:0] wdata,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] tx_data,
  input logic          rx_valid,
  input logic          en_q,
  input logic          mode_q,
  input logic          ovr_q,
  input logic          busy,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          sclk_oe,
  input logic          mosi_oe,
  input logic          miso_oe
);
  // R5
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !(wr_en && reg_sel == 2'd0)) |=> (tx_valid && $stable(tx_data)));
  // R2
  tx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == CW'(DEPTH) && !(tx_valid && tx_ready)) |=> tx_cnt == CW'(DEPTH));
  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel == 2'd1 && rx_cnt == '0 && !rx_valid) |=> rx_cnt == '0);
  // R6
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(mode_q));
  // R7
  line_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(miso_oe && (sclk_oe || mosi_oe)));
  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !(wr_en && reg_sel == 2'd0 && wdata[4])) |=> ovr_q);
  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt != '0) |-> busy);
endmodule

bind sport_regfront sport_regfront_chk #(.DW(DW), .CW($clog2(DEPTH)+1), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_valid(rx_valid), .en_q(en_q), .mode_q(mode_q), .ovr_q(ovr_q), .busy(busy),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .sclk_oe(sclk_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe)
);

// File: tb/sim_sport_regfront.sv
module sim_sport_regfront;
  logic clk = 0, rst_n = 0;
  logic [1:0] reg_sel = 0;
  logic wr_en = 0, rd_en = 0, tx_ready = 0, rx_valid = 0, shifter_active = 0;
  logic [15:0] wdata = 0, rx_data = 0, rdata, tx_data;
  logic tx_valid, sclk_oe, mosi_oe, ssel_oe, miso_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sport_regfront u0 (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(bit en, bit md, bit sod, bit clr, logic [3:0] len);
    return {4'b0, len, 3'b0, clr, sod, md, en, 1'b0};
  endfunction

  task automatic wr(logic [1:0] s, logic [15:0] d);
    @(negedge clk); reg_sel = s; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] s, output logic [15:0] v);
    @(negedge clk); reg_sel = s; rd_en = 1; #1 v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic rxp(logic [15:0] d);
    @(negedge clk); rx_data = d; rx_valid = 1;
    @(negedge clk); rx_valid = 0;
  endtask

  function automatic logic [3:0] oes();
    return {sclk_oe, mosi_oe, ssel_oe, miso_oe};
  endfunction

  task automatic t_reset;
    logic [15:0] v;
    rd(2, v); chk("R1 status", v, 16'h0003);
    rd(0, v); chk("R1 ctrl", v, 16'h0F00);
    rd(1, v); chk("R1 data", v, 16'h0000);
    chk("R1 oe", 16'(oes()), 16'h0);
  endtask

  task automatic t_tx;
    logic [15:0] v;
    for (int i = 0; i < 9; i++) wr(1, 16'h1100 + 16'(i));
    rd(2, v); chk("R2 full status", v & 16'h0013, 16'h0010);
    chk("R5 no offer when disabled", 16'(tx_valid), 16'h0);
    wr(0, cw(1, 0, 0, 0, 4'hF));
    @(negedge clk); tx_ready = 1;
    for (int i = 0; i < 8; i++) begin
      chk("R5 offered frame", tx_data, 16'h1100 + 16'(i));
      chk("R5 valid", 16'(tx_valid), 16'h1);
      @(negedge clk);
    end
    chk("R2 ninth dropped", 16'(tx_valid), 16'h0);
    tx_ready = 0;
    rd(2, v); chk("R9 idle not busy", v & 16'h0013, 16'h0003);
    shifter_active = 1;
    rd(2, v); chk("R9 busy from shifter", v & 16'h0010, 16'h0010);
    shifter_active = 0;
    wr(1, 16'hCAFE);
    chk("R5 immediate handoff", tx_data, 16'hCAFE);
    chk("R5 immediate valid", 16'(tx_valid), 16'h1);
    @(negedge clk); tx_ready = 1; @(negedge clk); tx_ready = 0;
    wr(0, cw(0, 0, 0, 0, 4'hF));
    for (int i = 0; i < 8; i++) wr(1, 16'h2200 + 16'(i));
    wr(0, cw(1, 0, 0, 0, 4'hF));
    @(negedge clk); tx_ready = 1; reg_sel = 1; wdata = 16'h22EE; wr_en = 1;
    chk("R2 handoff while full", tx_data, 16'h2200);
    @(negedge clk); wr_en = 0;
    for (int i = 1; i < 9; i++) begin
      chk("R2 late frame order", tx_data, (i == 8) ? 16'h22EE : 16'h2200 + 16'(i));
      @(negedge clk);
    end
    tx_ready = 0;
    chk("R2 drained", 16'(tx_valid), 16'h0);
  endtask

  task automatic t_rx;
    logic [15:0] v;
    wr(0, cw(1, 0, 0, 0, 4'd7));
    rxp(16'hABCD); rxp(16'h1234);
    rd(1, v); chk("R3 8-bit oldest", v, 16'h00CD);
    rd(1, v); chk("R3 8-bit second", v, 16'h0034);
    wr(0, cw(1, 0, 0, 0, 4'd0));
    rxp(16'hFFFF); rd(1, v); chk("R3 clamp 4-bit", v, 16'h000F);
    wr(0, cw(1, 0, 0, 0, 4'hF));
    rxp(16'hBEEF); rd(1, v); chk("R3 16-bit", v, 16'hBEEF);
    rd(1, v); chk("R4 empty read", v, 16'h0000);
    rxp(16'h0055); rd(1, v); chk("R4 next after empty", v, 16'h0055);
    rd(2, v); chk("R4 empty again", v & 16'h0004, 16'h0000);
  endtask

  task automatic t_overrun;
    logic [15:0] v;
    for (int i = 0; i < 8; i++) rxp(16'h3300 + 16'(i));
    rd(2, v); chk("R8 full no ovr", v & 16'h002C, 16'h000C);
    rxp(16'h33FF);
    rd(2, v); chk("R8 ovr set", v & 16'h0020, 16'h0020);
    wr(0, cw(1, 0, 0, 0, 4'hF));
    rd(2, v); chk("R8 sticky", v & 16'h0020, 16'h0020);
    @(negedge clk); rx_valid = 1; rx_data = 16'h3344; reg_sel = 0;
    wdata = cw(1, 0, 0, 1, 4'hF); wr_en = 1;
    @(negedge clk); rx_valid = 0; wr_en = 0;
    rd(2, v); chk("R8 set wins", v & 16'h0020, 16'h0020);
    wr(0, cw(1, 0, 0, 1, 4'hF));
    rd(2, v); chk("R8 cleared", v & 16'h0020, 16'h0000);
    @(negedge clk); reg_sel = 1; rd_en = 1; rx_valid = 1; rx_data = 16'h33AA;
    #1 v = rdata;
    @(negedge clk); rd_en = 0; rx_valid = 0;
    chk("R10 pop value", v, 16'h3300);
    rd(2, v); chk("R10 full no ovr", v & 16'h0028, 16'h0008);
    for (int i = 1; i < 9; i++) begin
      rd(1, v); chk("R10 order", v, (i == 8) ? 16'h33AA : 16'h3300 + 16'(i));
    end
    rd(2, v); chk("R10 empty", v & 16'h0004, 16'h0000);
  endtask

  task automatic t_mode;
    logic [15:0] v;
    wr(0, cw(1, 0, 0, 0, 4'hF));
    chk("R7 master oe", 16'(oes()), 16'hE);
    wr(0, cw(1, 1, 0, 0, 4'hF));
    rd(0, v); chk("R6 locked", v & 16'h0004, 16'h0000);
    wr(0, cw(1, 0, 1, 0, 4'hF));
    chk("R7 disable ignored in master", 16'(oes()), 16'hE);
    wr(0, cw(0, 1, 0, 0, 4'hF));
    rd(0, v); chk("R6 locked on disable write", v & 16'h0004, 16'h0000);
    chk("R7 disabled oe", 16'(oes()), 16'h0);
    wr(0, cw(1, 1, 0, 0, 4'hF));
    rd(0, v); chk("R6 mode taken", v & 16'h0004, 16'h0004);
    chk("R7 slave oe", 16'(oes()), 16'h1);
    wr(0, cw(1, 1, 1, 0, 4'hF));
    chk("R7 slave disabled", 16'(oes()), 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_tx();
    t_rx();
    t_overrun();
    t_mode();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule